// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Decoder

A synthesizable model of a single-ported synchronous static memory with a 32-bit data path split into four byte lanes. On each rising clock edge it samples three chip enables, a processor-side and a controller-side address strobe, an advance input, the write qualifiers and a sleep input. From these it decides whether to deselect, to open a new access at the external address, to step a burst to the next address, or to stay on the current address. The resulting cycle is a read or a write.

Read data is flow-through: it appears on the output bus during the cycle that follows the edge that registered the address. The bus is enabled by an asynchronous, active-low output enable. The enable has no effect during write cycles, while deselected and while asleep. The bus is modelled as a data vector plus a drive flag. It reads zero whenever it is not driven.

Top module: `sync_burst_sram`

## Requirements
- R1: While `sleep_i` is 1, `dq_oe_o` is 0 at once and no write takes place. An edge sampled in sleep leaves the block deselected.
- R2: The combined write is active when `gwrite_n_i` is 0, or when `bwrite_n_i` is 0 and at least one bit of `lane_n_i` is 0. With `bwrite_n_i` 0 and `lane_n_i` all ones, the cycle is not a write.
- R3: The block is selected only when `en1_n_i`=0, `en2_i`=1 and `en3_n_i`=0. A processor strobe (with `en1_n_i` 0) or a controller strobe that arrives while not selected deselects the block: the bus stays undriven until a new access loads. Continue cycles do not leave the deselected state.
- R4: With `en1_n_i`=1 the processor strobe is ignored. If the controller strobe is also high, the cycle is a continue or hold cycle of the current burst.
- R5: When selected, a low processor strobe loads `addr_i` and starts a read, whatever the write inputs are. No write happens on that edge.
- R6: When selected, with the processor strobe high and the controller strobe low, the block loads `addr_i`. It starts a write if the combined write is active, and a read otherwise.
- R7: With no strobe in effect during an open burst, `adv_n_i`=0 steps to the next address and `adv_n_i`=1 holds the current address. The cycle is a read or a write according to the combined write.
- R8: A write applied on a hold cycle writes the current address. This includes the address of a read just opened by the processor strobe.
- R9: `dq_oe_o` is 1 only during a read cycle with `oe_n_i`=0, and it follows `oe_n_i` without waiting for a clock edge. During write cycles it is 0 for either level of `oe_n_i`.
- R10: A burst step increments only address bits [1:0] and wraps from 3 to 0. The upper address bits keep their loaded value.
- R11: A write with `gwrite_n_i`=0 updates all four lanes. Otherwise it updates only those lanes i whose `lane_n_i[i]` is 0. Lane i is `dq` bits [8i+7:8i].
- R12: After reset the block is deselected with `dq_oe_o`=0. Read data of the registered address appears on `dq_o` in the cycle after the loading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Sleep, active high |
| en1_n_i | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| en2_i | input | 1 | Chip enable 2, active high |
| en3_n_i | input | 1 | Chip enable 3, active low |
| pstrobe_n_i | input | 1 | Processor address strobe, active low |
| cstrobe_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| gwrite_n_i | input | 1 | Global write, active low |
| bwrite_n_i | input | 1 | Byte-write enable, active low |
| lane_n_i | input | 4 | Per-lane write select, active low |
| addr_i | input | AW | External address |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | 32 | Write data |
| dq_o | output | 32 | Read data, zero when not driven |
| dq_oe_o | output | 1 | Bus drive flag |

## Verification
The bench builds the block with a 4-bit address, so 16 words. A burst that starts at address 6 then crosses from 7 to 4, and the bench can see that the upper bits stay fixed while the two low bits wrap. The small array lets every word the bench reads be written first. As a result, each lane merge, each hold-cycle write and each write that must be suppressed (processor strobe, sleep, no lane selected) shows up as a definite value on `dq_o`.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [1:0] {
        CYC_NONE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;

    typedef enum logic [1:0] {
        ADR_HOLD = 2'd0,
        ADR_LOAD = 2'd1,
        ADR_NEXT = 2'd2
    } adr_act_e;

endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
    import sbs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             sleep_i,
    input  logic             en1_n_i,
    input  logic             en2_i,
    input  logic             en3_n_i,
    input  logic             pstrobe_n_i,
    input  logic             cstrobe_n_i,
    input  logic             adv_n_i,
    input  logic             gwrite_n_i,
    input  logic             bwrite_n_i,
    input  logic [LANES-1:0] lane_n_i,
    input  cyc_e             cyc_q_i,
    output adr_act_e         act_o,
    output cyc_e             cyc_d_o,
    output logic [LANES-1:0] lane_we_o
);

    logic selected;
    logic p_req;
    logic c_req;
    logic wr_any;

    always_comb begin
        selected = !en1_n_i && en2_i && !en3_n_i;
        p_req    = !pstrobe_n_i && !en1_n_i;
        c_req    = !cstrobe_n_i;
        wr_any   = !gwrite_n_i || (!bwrite_n_i && !(&lane_n_i));

        act_o   = ADR_HOLD;
        cyc_d_o = CYC_NONE;
        if (sleep_i) begin
            act_o   = ADR_HOLD;
            cyc_d_o = CYC_NONE;
        end else if (p_req) begin
            if (selected) begin
                act_o   = ADR_LOAD;
                cyc_d_o = CYC_READ;
            end
        end else if (c_req) begin
            if (selected) begin
                act_o   = ADR_LOAD;
                cyc_d_o = wr_any ? CYC_WRITE : CYC_READ;
            end
        end else if (cyc_q_i != CYC_NONE) begin
            act_o   = adv_n_i ? ADR_HOLD : ADR_NEXT;
            cyc_d_o = wr_any ? CYC_WRITE : CYC_READ;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            lane_we_o[i] = (cyc_d_o == CYC_WRITE) && (!gwrite_n_i || !lane_n_i[i]);
        end
    end

endmodule

// File: rtl/sbs_burst.sv
module sbs_burst
    import sbs_pkg::*;
#(
    parameter int AW = 6,
    parameter int BB = 2
) (
    input  adr_act_e        act_i,
    input  logic [AW-1:0]   addr_q_i,
    input  logic [AW-1:0]   ext_addr_i,
    output logic [AW-1:0]   addr_d_o
);

    localparam int HI = AW - BB;

    logic [BB-1:0] low_inc;

    always_comb begin
        low_inc = addr_q_i[BB-1:0] + BB'(1);
        case (act_i)
            ADR_LOAD: addr_d_o = ext_addr_i;
            ADR_NEXT: addr_d_o = {addr_q_i[AW-1:BB], low_inc};
            default:  addr_d_o = addr_q_i;
        endcase
    end

    if (HI < 1) begin : g_bad
        initial $error("sbs_burst: AW must exceed BB");
    end

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic [LANES-1:0]   we_i,
    input  logic [AW-1:0]      waddr_i,
    input  logic [LANES*8-1:0] wdata_i,
    input  logic [AW-1:0]      raddr_i,
    output logic [LANES*8-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [7:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we_i[i]) begin
                mem[waddr_i] <= wdata_i[8*i +: 8];
            end
        end

        always_comb begin
            rdata_o[8*i +: 8] = mem[raddr_i];
        end
    end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 4,
    parameter int BB    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_i,
    input  logic               en1_n_i,
    input  logic               en2_i,
    input  logic               en3_n_i,
    input  logic               pstrobe_n_i,
    input  logic               cstrobe_n_i,
    input  logic               adv_n_i,
    input  logic               gwrite_n_i,
    input  logic               bwrite_n_i,
    input  logic [LANES-1:0]   lane_n_i,
    input  logic [AW-1:0]      addr_i,
    input  logic               oe_n_i,
    input  logic [LANES*8-1:0] wdata_i,
    output logic [LANES*8-1:0] dq_o,
    output logic               dq_oe_o
);

    localparam int DW = LANES * 8;

    typedef struct packed {
        cyc_e          cyc;
        logic [AW-1:0] addr;
    } state_t;

    state_t            st_d;
    state_t            st_q;
    adr_act_e          act;
    cyc_e              cyc_next;
    logic [LANES-1:0]  lane_we;
    logic [AW-1:0]     addr_next;
    logic [DW-1:0]     rdata;

    sbs_decode #(.LANES(LANES)) u_dec (
        .sleep_i    (sleep_i),
        .en1_n_i    (en1_n_i),
        .en2_i      (en2_i),
        .en3_n_i    (en3_n_i),
        .pstrobe_n_i(pstrobe_n_i),
        .cstrobe_n_i(cstrobe_n_i),
        .adv_n_i    (adv_n_i),
        .gwrite_n_i (gwrite_n_i),
        .bwrite_n_i (bwrite_n_i),
        .lane_n_i   (lane_n_i),
        .cyc_q_i    (st_q.cyc),
        .act_o      (act),
        .cyc_d_o    (cyc_next),
        .lane_we_o  (lane_we)
    );

    sbs_burst #(.AW(AW), .BB(BB)) u_burst (
        .act_i     (act),
        .addr_q_i  (st_q.addr),
        .ext_addr_i(addr_i),
        .addr_d_o  (addr_next)
    );

    sbs_array #(.AW(AW), .LANES(LANES)) u_mem (
        .clk    (clk),
        .we_i   (lane_we),
        .waddr_i(addr_next),
        .wdata_i(wdata_i),
        .raddr_i(st_q.addr),
        .rdata_o(rdata)
    );

    always_comb begin
        st_d      = st_q;
        st_d.cyc  = cyc_next;
        st_d.addr = addr_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cyc  <= CYC_NONE;
            st_q.addr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        dq_oe_o = (st_q.cyc == CYC_READ) && !oe_n_i && !sleep_i;
        dq_o    = dq_oe_o ? rdata : '0;
    end

endmodule

// File: rtl/sbs_check.sv
module sbs_check
    import sbs_pkg::*;
#(
    parameter int AW = 6,
    parameter int BB = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sleep_i,
    input logic          en1_n_i,
    input logic          en2_i,
    input logic          en3_n_i,
    input logic          pstrobe_n_i,
    input logic          cstrobe_n_i,
    input logic          adv_n_i,
    input logic          oe_n_i,
    input logic          dq_oe_o,
    input cyc_e          cyc_q,
    input logic [AW-1:0] addr_q
);

    logic sel;
    logic cont;
    assign sel  = !en1_n_i && en2_i && !en3_n_i;
    assign cont = !sleep_i && cstrobe_n_i && (pstrobe_n_i || en1_n_i) && (cyc_q != CYC_NONE);

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (!dq_oe_o || !sleep_i) && (cyc_q == CYC_NONE)); // R1

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && !sel && (!cstrobe_n_i || (!pstrobe_n_i && !en1_n_i))) |=> !dq_oe_o); // R3

    AST_PSTROBE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && sel && !pstrobe_n_i) |=> (cyc_q == CYC_READ)); // R5

    AST_OE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n_i || cyc_q != CYC_READ) |-> !dq_oe_o); // R9

    AST_BURST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && !adv_n_i) |=> (addr_q[BB-1:0] == $past(addr_q[BB-1:0]) + BB'(1))
                               && (addr_q[AW-1:BB] == $past(addr_q[AW-1:BB]))); // R10

    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && adv_n_i) |=> $stable(addr_q)); // R7

endmodule

bind sync_burst_sram sbs_check #(.AW(AW), .BB(BB)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_i    (sleep_i),
    .en1_n_i    (en1_n_i),
    .en2_i      (en2_i),
    .en3_n_i    (en3_n_i),
    .pstrobe_n_i(pstrobe_n_i),
    .cstrobe_n_i(cstrobe_n_i),
    .adv_n_i    (adv_n_i),
    .oe_n_i     (oe_n_i),
    .dq_oe_o    (dq_oe_o),
    .cyc_q      (st_q.cyc),
    .addr_q     (st_q.addr)
);

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;

    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_i, en1_n_i, en2_i, en3_n_i;
    logic          pstrobe_n_i, cstrobe_n_i, adv_n_i;
    logic          gwrite_n_i, bwrite_n_i, oe_n_i;
    logic [3:0]    lane_n_i;
    logic [AW-1:0] addr_i;
    logic [31:0]   wdata_i;
    logic [31:0]   dq_o;
    logic          dq_oe_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sync_burst_sram #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i),
        .en1_n_i(en1_n_i), .en2_i(en2_i), .en3_n_i(en3_n_i),
        .pstrobe_n_i(pstrobe_n_i), .cstrobe_n_i(cstrobe_n_i), .adv_n_i(adv_n_i),
        .gwrite_n_i(gwrite_n_i), .bwrite_n_i(bwrite_n_i), .lane_n_i(lane_n_i),
        .addr_i(addr_i), .oe_n_i(oe_n_i), .wdata_i(wdata_i),
        .dq_o(dq_o), .dq_oe_o(dq_oe_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        sleep_i = 0; en1_n_i = 0; en2_i = 1; en3_n_i = 0;
        pstrobe_n_i = 1; cstrobe_n_i = 1; adv_n_i = 1;
        gwrite_n_i = 1; bwrite_n_i = 1; lane_n_i = 4'hF;
        oe_n_i = 0; addr_i = '0; wdata_i = '0;
    endtask

    task automatic wr_word(logic [AW-1:0] a, logic [31:0] d);
        idle();
        cstrobe_n_i = 0; gwrite_n_i = 0; addr_i = a; wdata_i = d;
        tick();
        idle();
    endtask

    task automatic rd_start(logic [AW-1:0] a);
        idle();
        pstrobe_n_i = 0; addr_i = a;
        tick();
        idle();
    endtask

    task automatic t_reset();
        idle();
        #1;
        chk("R12 reset oe", {31'd0, dq_oe_o}, 32'd0);
        rst_n = 1;
        tick();
        chk("R12 idle after reset", {31'd0, dq_oe_o}, 32'd0);
    endtask

    task automatic t_write_read();
        for (int i = 0; i < 4; i++) wr_word(AW'(i), 32'hC0DE_0000 + i);
        chk("R9 write cycle undriven", {31'd0, dq_oe_o}, 32'd0);
        rd_start(AW'(2));
        chk("R12 flow-through oe", {31'd0, dq_oe_o}, 32'd1);
        chk("R5 pstrobe read", dq_o, 32'hC0DE_0002);
        idle(); cstrobe_n_i = 0; addr_i = AW'(3);
        tick(); idle();
        chk("R6 cstrobe read", dq_o, 32'hC0DE_0003);
    endtask

    task automatic t_burst();
        logic [31:0] v [4] = '{32'hA0A0_0006, 32'hB1B1_0007, 32'hC2C2_0004, 32'hD3D3_0005};
        wr_word(AW'(6), v[0]);
        for (int i = 1; i < 4; i++) begin
            idle(); adv_n_i = 0; gwrite_n_i = 0; wdata_i = v[i];
            tick();
        end
        idle();
        rd_start(AW'(4));
        chk("R10 wrap landed at 4", dq_o, v[2]);
        rd_start(AW'(6));
        chk("R7 burst start", dq_o, v[0]);
        for (int i = 1; i < 5; i++) begin
            idle(); adv_n_i = 0;
            tick();
            chk("R10 burst step", dq_o, v[i % 4]);
        end
        idle();
        tick();
        chk("R7 hold keeps address", dq_o, v[0]);
    endtask

    task automatic t_hold_write();
        wr_word(AW'(9), 32'h1111_9999);
        rd_start(AW'(9));
        chk("R8 pre-read", dq_o, 32'h1111_9999);
        idle(); gwrite_n_i = 0; wdata_i = 32'h5A5A_0909;
        tick();
        chk("R9 write masks oe", {31'd0, dq_oe_o}, 32'd0);
        idle();
        tick();
        chk("R8 hold write at current", dq_o, 32'h5A5A_0909);
    endtask

    task automatic t_pstrobe_ignores_write();
        wr_word(AW'(2), 32'h2222_2222);
        idle(); pstrobe_n_i = 0; addr_i = AW'(2); gwrite_n_i = 0; wdata_i = 32'hDEAD_BEEF;
        tick();
        chk("R5 pstrobe is read", dq_o, 32'h2222_2222);
        idle();
        rd_start(AW'(2));
        chk("R5 no write on pstrobe", dq_o, 32'h2222_2222);
    endtask

    task automatic t_lanes();
        wr_word(AW'(10), 32'h1122_3344);
        idle(); cstrobe_n_i = 0; addr_i = AW'(10); bwrite_n_i = 0; lane_n_i = 4'b1010;
        wdata_i = 32'hAABB_CCDD;
        tick(); idle();
        rd_start(AW'(10));
        chk("R11 lane merge", dq_o, 32'h11BB_33DD);
        idle(); cstrobe_n_i = 0; addr_i = AW'(10); bwrite_n_i = 0; lane_n_i = 4'hF;
        wdata_i = 32'hFFFF_FFFF;
        tick();
        chk("R2 no lane means read", dq_o, 32'h11BB_33DD);
        idle(); cstrobe_n_i = 0; addr_i = AW'(10); bwrite_n_i = 1; lane_n_i = 4'h0;
        wdata_i = 32'hFFFF_FFFF;
        tick();
        chk("R2 lanes without bwe is read", dq_o, 32'h11BB_33DD);
        idle(); cstrobe_n_i = 0; addr_i = AW'(10); gwrite_n_i = 0; lane_n_i = 4'b1110;
        wdata_i = 32'h0102_0304;
        tick(); idle();
        rd_start(AW'(10));
        chk("R11 global write all lanes", dq_o, 32'h0102_0304);
    endtask

    task automatic t_oe();
        rd_start(AW'(1));
        oe_n_i = 1;
        #1;
        chk("R9 oe high async", {31'd0, dq_oe_o}, 32'd0);
        oe_n_i = 0;
        #1;
        chk("R9 oe low async", {31'd0, dq_oe_o}, 32'd1);
        chk("R9 data with oe", dq_o, 32'hC0DE_0001);
    endtask

    task automatic t_deselect();
        rd_start(AW'(0));
        idle(); en2_i = 0; pstrobe_n_i = 0; addr_i = AW'(1);
        tick();
        chk("R3 deselect by en2", {31'd0, dq_oe_o}, 32'd0);
        idle(); adv_n_i = 0;
        tick();
        chk("R3 stays deselected", {31'd0, dq_oe_o}, 32'd0);
        rd_start(AW'(0));
        idle(); en3_n_i = 1; cstrobe_n_i = 0; gwrite_n_i = 0; addr_i = AW'(0);
        wdata_i = 32'hBAD0_BAD0;
        tick();
        chk("R3 deselect by en3", {31'd0, dq_oe_o}, 32'd0);
        idle();
        rd_start(AW'(0));
        chk("R3 deselected write blocked", dq_o, 32'hC0DE_0000);
    endtask

    task automatic t_en1();
        wr_word(AW'(12), 32'h0000_0C0C);
        wr_word(AW'(13), 32'h0000_0D0D);
        rd_start(AW'(12));
        idle(); en1_n_i = 1; pstrobe_n_i = 0; adv_n_i = 0; addr_i = AW'(3);
        tick();
        chk("R4 en1 high pstrobe ignored oe", {31'd0, dq_oe_o}, 32'd1);
        chk("R4 en1 high continues burst", dq_o, 32'h0000_0D0D);
        idle(); en1_n_i = 1; cstrobe_n_i = 0; addr_i = AW'(3);
        tick();
        chk("R3 en1 high cstrobe deselects", {31'd0, dq_oe_o}, 32'd0);
        idle();
    endtask

    task automatic t_sleep();
        rd_start(AW'(0));
        sleep_i = 1;
        #1;
        chk("R1 sleep tristates", {31'd0, dq_oe_o}, 32'd0);
        cstrobe_n_i = 0; gwrite_n_i = 0; addr_i = AW'(0); wdata_i = 32'hFACE_FACE;
        tick();
        idle(); adv_n_i = 0;
        tick();
        chk("R1 deselected after sleep", {31'd0, dq_oe_o}, 32'd0);
        rd_start(AW'(0));
        chk("R1 no write in sleep", dq_o, 32'hC0DE_0000);
    endtask

    initial begin
        idle();
        repeat (2) @(posedge clk);
        #1;
        t_reset();
        t_write_read();
        t_burst();
        t_hold_write();
        t_pstrobe_ignores_write();
        t_lanes();
        t_oe();
        t_deselect();
        t_en1();
        t_sleep();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule